// File: doc/BRIEF.md
# Host Command Dispatcher with Seconds Clock

This block sits behind the byte-level link from the host processor. It takes in one host packet at a time and handles it as a complete unit. The first byte of a packet selects its class. Controller commands are decoded and carried out here, and each one returns a reply packet on a separate byte stream. Packets addressed to the peripheral bus are not interpreted: their payload bytes are handed unchanged to a forwarding stream for a separate bus engine. Any other class is dropped.

The block keeps three pieces of state for the peripheral-bus engine: an auto-poll enable, a poll rate and a 16-bit device mask. It also keeps a 32-bit count of seconds since the start of 1904, which advances on a tick produced by dividing the clock. Two commands produce single-cycle requests to the system: one to power down and one to reset. Every command code is a parameter. The host is expected to wait for a reply to finish before it sends the next packet.

Top module: `host_cmd_dispatch`

## Requirements
- R1: After reset, auto-poll is off, the rate is RATE_RST (20), the mask is MASK_RST (0xFFFF), both request outputs are low, no stream is active, and the seconds value starts from RESET_SECS.
- R2: A packet is marked by `rx_first` on its first byte and carries its total length on `rx_len`. Every reply starts on the outputs in the second cycle after the last input byte was taken. Its bytes then appear on consecutive cycles, with `tx_first` on byte 0 only and `tx_len` holding the reply length throughout.
- R3: A known command whose argument count is wrong replies with the four bytes 2, 5, 1, command. Its state is left untouched.
- R4: An unknown command byte replies with the four bytes 2, 2, 1, command.
- R5: The argument count is the packet length minus 2 and must match exactly: auto-poll takes 1, set-rate takes 1, device list takes 2, power-down takes 0, reset takes 0, get-time takes 0 and set-time takes 4. A successful command replies with 1, 0, command, followed by any result bytes.
- R6: A set-rate argument of 0 is rejected with the bad-parameter reply and leaves the rate unchanged. A non-zero argument becomes the new rate.
- R7: Set device list loads the mask as {first argument, second argument}, so the first argument is the high byte.
- R8: Auto-poll with a non-zero argument turns polling on, and with a zero argument turns it off.
- R9: Get-time replies with 7 bytes: the header followed by the seconds value, most significant byte first. Set-time loads the seconds value from its four arguments in the same byte order.
- R10: The seconds value rises by one on every TICK_DIV-th clock edge after reset. A set-time load that falls on a tick edge takes the loaded value, and that tick is lost.
- R11: Power-down and reset each raise their own request output for exactly one cycle. That cycle is the one in which the first reply byte is shown.
- R12: For a class-0 packet of length L, bytes 1 to L-1 appear on `fwd_data`, each one cycle after it was taken. `fwd_first` marks byte 1 and `fwd_len` reads L-1. No reply is produced.
- R13: Packets of any class other than 0 or 1, and class-1 packets shorter than two bytes, produce no output and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Input byte valid |
| rx_first | input | 1 | Marks the first byte of a packet |
| rx_data | input | 8 | Input packet byte |
| rx_len | input | LEN_W | Total packet length, sampled with the first byte |
| tx_valid | output | 1 | Reply byte valid |
| tx_first | output | 1 | Marks reply byte 0 |
| tx_data | output | 8 | Reply byte |
| tx_len | output | LEN_W | Reply length |
| fwd_valid | output | 1 | Forwarded peripheral-bus byte valid |
| fwd_first | output | 1 | Marks the first forwarded byte |
| fwd_data | output | 8 | Forwarded byte |
| fwd_len | output | LEN_W | Forwarded payload length |
| autopoll_en | output | 1 | Auto-poll enable |
| poll_rate | output | 8 | Poll rate |
| poll_mask | output | 16 | Poll device mask |
| powerdown_req | output | 1 | One-cycle power-down request |
| sysreset_req | output | 1 | One-cycle system reset request |

## Verification
The two functions that can land on the same clock edge are the seconds tick and a set-time load. The bench uses a short divider. It repeats a set-time followed by a get-time, and before each pair it inserts one more idle cycle than the time before. Over these repetitions the load edge passes through every phase of the divider, so some loads fall exactly on a tick edge. The expected get-time result is computed from edge counts: the loaded value plus the ticks that occur strictly after the load edge. A design that let the tick win would show up as a value that is one too high.

// File: rtl/hcd_pkg.sv
package hcd_pkg;

    localparam int unsigned MAX_ARGS   = 4;
    localparam int unsigned HDR_BYTES  = 3;
    localparam int unsigned TIME_BYTES = 4;
    localparam int unsigned ERR_BYTES  = 4;
    localparam int unsigned RX_KEEP    = 2 + MAX_ARGS;
    localparam int unsigned TX_MAX     = HDR_BYTES + TIME_BYTES;
    localparam int unsigned TX_LEN_W   = $clog2(TX_MAX + 1);

    typedef logic [7:0] byte_t;

    // packet classes carried in byte 0
    localparam byte_t PT_BUS = 8'd0;
    localparam byte_t PT_CMD = 8'd1;
    localparam byte_t PT_ERR = 8'd2;

    // error codes carried in byte 1 of an error reply
    localparam byte_t ERR_UNKNOWN = 8'd2;
    localparam byte_t ERR_BADARG  = 8'd5;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_AUTOPOLL,
        OP_SET_RATE,
        OP_SET_DEVLIST,
        OP_POWERDOWN,
        OP_RESET,
        OP_GET_TIME,
        OP_SET_TIME
    } op_e;

    function automatic int unsigned op_argc(input op_e op);
        case (op)
            OP_AUTOPOLL:    return 1;
            OP_SET_RATE:    return 1;
            OP_SET_DEVLIST: return 2;
            OP_SET_TIME:    return 4;
            default:        return 0;
        endcase
    endfunction

endpackage

// File: rtl/hcd_rx_collect.sv
module hcd_rx_collect
    import hcd_pkg::*;
#(
    parameter int unsigned LEN_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_valid_i,
    input  logic                       rx_first_i,
    input  byte_t                      rx_data_i,
    input  logic [LEN_W-1:0]           rx_len_i,
    output logic                       done_o,
    output logic [LEN_W-1:0]           len_o,
    output byte_t [RX_KEEP-1:0]        bytes_o,
    output logic                       fwd_valid_o,
    output logic                       fwd_first_o,
    output byte_t                      fwd_data_o,
    output logic [LEN_W-1:0]           fwd_len_o
);

    typedef struct packed {
        logic                active;
        logic [LEN_W-1:0]    cnt;
        logic [LEN_W-1:0]    len;
        byte_t [RX_KEEP-1:0] bytes;
        logic                done;
        logic                fwd_valid;
        logic                fwd_first;
        byte_t               fwd_data;
        logic [LEN_W-1:0]    fwd_len;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.done      = 1'b0;
        st_d.fwd_valid = 1'b0;
        st_d.fwd_first = 1'b0;
        if (rx_valid_i && rx_first_i) begin
            if (rx_len_i != '0) begin
                st_d.bytes[0] = rx_data_i;
                st_d.len      = rx_len_i;
                st_d.cnt      = LEN_W'(1);
                st_d.active   = (rx_len_i != LEN_W'(1));
                st_d.done     = (rx_len_i == LEN_W'(1));
            end else begin
                st_d.active = 1'b0;
            end
        end else if (rx_valid_i && st_q.active) begin
            for (int k = 1; k < RX_KEEP; k++) begin
                if (st_q.cnt == LEN_W'(k)) begin
                    st_d.bytes[k] = rx_data_i;
                end
            end
            st_d.cnt = st_q.cnt + LEN_W'(1);
            if (st_q.cnt == st_q.len - LEN_W'(1)) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end
            if (st_q.bytes[0] == PT_BUS) begin
                st_d.fwd_valid = 1'b1;
                st_d.fwd_first = (st_q.cnt == LEN_W'(1));
                st_d.fwd_data  = rx_data_i;
                st_d.fwd_len   = st_q.len - LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o      = st_q.done;
    assign len_o       = st_q.len;
    assign bytes_o     = st_q.bytes;
    assign fwd_valid_o = st_q.fwd_valid;
    assign fwd_first_o = st_q.fwd_first;
    assign fwd_data_o  = st_q.fwd_data;
    assign fwd_len_o   = st_q.fwd_len;

    AST_RX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.cnt < st_q.len)); // R12

    AST_RX_FWD_ONLY_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid_o |-> (bytes_o[0] == PT_BUS)); // R12

endmodule

// File: rtl/hcd_seconds.sv
module hcd_seconds #(
    parameter int unsigned TICK_DIV   = 50_000_000,
    parameter logic [31:0] RESET_SECS = 32'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic [31:0] load_val_i,
    output logic [31:0] secs_o
);

    localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [31:0]      secs;
    } sec_st_t;

    sec_st_t st_d, st_q;
    logic    tick;

    always_comb begin
        tick    = (st_q.div == DIV_LAST);
        st_d    = st_q;
        st_d.div = tick ? '0 : st_q.div + DIV_W'(1);
        if (load_i) begin
            st_d.secs = load_val_i;
        end else if (tick) begin
            st_d.secs = st_q.secs + 32'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.div  <= '0;
            st_q.secs <= RESET_SECS;
        end else begin
            st_q <= st_d;
        end
    end

    assign secs_o = st_q.secs;

    AST_SECS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (secs_o == $past(secs_o) || secs_o == $past(secs_o) + 32'd1)); // R10

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (secs_o == $past(load_val_i))); // R10

endmodule

// File: rtl/hcd_tx_serial.sv
module hcd_tx_serial
    import hcd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [TX_LEN_W-1:0] load_len_i,
    input  byte_t [TX_MAX-1:0]  load_bytes_i,
    output logic                valid_o,
    output logic                first_o,
    output byte_t               data_o,
    output logic [TX_LEN_W-1:0] len_o,
    output logic                busy_o
);

    typedef struct packed {
        logic                busy;
        logic [TX_LEN_W-1:0] idx;
        logic [TX_LEN_W-1:0] len;
        byte_t [TX_MAX-1:0]  bytes;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i && load_len_i != '0) begin
            st_d.bytes = load_bytes_i;
            st_d.len   = load_len_i;
            st_d.idx   = '0;
            st_d.busy  = 1'b1;
        end else if (st_q.busy) begin
            if (st_q.idx == st_q.len - TX_LEN_W'(1)) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.idx = st_q.idx + TX_LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.busy;
    assign first_o = st_q.busy && (st_q.idx == '0);
    assign data_o  = st_q.bytes[st_q.idx];
    assign len_o   = st_q.len;
    assign busy_o  = st_q.busy;

    AST_TX_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (st_q.idx < st_q.len)); // R2

    AST_TX_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && st_q.idx != st_q.len - TX_LEN_W'(1)) |=> (valid_o && !first_o)); // R2

    AST_TX_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !first_o) |-> $stable(len_o)); // R2

endmodule

// File: rtl/host_cmd_dispatch.sv
module host_cmd_dispatch
    import hcd_pkg::*;
#(
    parameter int unsigned TICK_DIV        = 50_000_000,
    parameter int unsigned LEN_W           = 8,
    parameter logic [31:0] RESET_SECS      = 32'd0,
    parameter logic [7:0]  RATE_RST        = 8'd20,
    parameter logic [15:0] MASK_RST        = 16'hFFFF,
    parameter logic [7:0]  CMD_AUTOPOLL    = 8'h01,
    parameter logic [7:0]  CMD_GET_TIME    = 8'h03,
    parameter logic [7:0]  CMD_SET_TIME    = 8'h09,
    parameter logic [7:0]  CMD_POWERDOWN   = 8'h0A,
    parameter logic [7:0]  CMD_RESET       = 8'h11,
    parameter logic [7:0]  CMD_SET_RATE    = 8'h14,
    parameter logic [7:0]  CMD_SET_DEVLIST = 8'h19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_first,
    input  logic [7:0]       rx_data,
    input  logic [LEN_W-1:0] rx_len,
    output logic             tx_valid,
    output logic             tx_first,
    output logic [7:0]       tx_data,
    output logic [LEN_W-1:0] tx_len,
    output logic             fwd_valid,
    output logic             fwd_first,
    output logic [7:0]       fwd_data,
    output logic [LEN_W-1:0] fwd_len,
    output logic             autopoll_en,
    output logic [7:0]       poll_rate,
    output logic [15:0]      poll_mask,
    output logic             powerdown_req,
    output logic             sysreset_req
);

    typedef struct packed {
        logic        autopoll;
        byte_t       rate;
        logic [15:0] mask;
        logic        pwr;
        logic        rst;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                rx_done;
    logic [LEN_W-1:0]    rx_len_q;
    byte_t [RX_KEEP-1:0] rx_bytes;
    logic                tx_busy;
    logic [TX_LEN_W-1:0] tx_len_s;
    logic [31:0]         secs;

    op_e                 op;
    byte_t               cmd;
    logic [LEN_W-1:0]    nargs;
    logic                take;
    logic                args_ok;
    logic                rate_ok;
    byte_t [TX_MAX-1:0]  resp;
    logic [TX_LEN_W-1:0] resp_len;
    logic                time_load;
    logic [31:0]         time_val;

    hcd_rx_collect #(
        .LEN_W (LEN_W)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid_i  (rx_valid),
        .rx_first_i  (rx_first),
        .rx_data_i   (rx_data),
        .rx_len_i    (rx_len),
        .done_o      (rx_done),
        .len_o       (rx_len_q),
        .bytes_o     (rx_bytes),
        .fwd_valid_o (fwd_valid),
        .fwd_first_o (fwd_first),
        .fwd_data_o  (fwd_data),
        .fwd_len_o   (fwd_len)
    );

    hcd_seconds #(
        .TICK_DIV   (TICK_DIV),
        .RESET_SECS (RESET_SECS)
    ) u_secs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (time_load),
        .load_val_i (time_val),
        .secs_o     (secs)
    );

    hcd_tx_serial u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (take),
        .load_len_i   (resp_len),
        .load_bytes_i (resp),
        .valid_o      (tx_valid),
        .first_o      (tx_first),
        .data_o       (tx_data),
        .len_o        (tx_len_s),
        .busy_o       (tx_busy)
    );

    assign tx_len = LEN_W'(tx_len_s);

    // command decode: earlier entries win if two parameters collide
    always_comb begin
        cmd = rx_bytes[1];
        if      (cmd == CMD_AUTOPOLL)    op = OP_AUTOPOLL;
        else if (cmd == CMD_SET_RATE)    op = OP_SET_RATE;
        else if (cmd == CMD_SET_DEVLIST) op = OP_SET_DEVLIST;
        else if (cmd == CMD_POWERDOWN)   op = OP_POWERDOWN;
        else if (cmd == CMD_RESET)       op = OP_RESET;
        else if (cmd == CMD_GET_TIME)    op = OP_GET_TIME;
        else if (cmd == CMD_SET_TIME)    op = OP_SET_TIME;
        else                             op = OP_NONE;
        nargs   = rx_len_q - LEN_W'(2);
        args_ok = (nargs == LEN_W'(op_argc(op)));
        rate_ok = !(op == OP_SET_RATE && rx_bytes[2] == 8'd0);
        take    = rx_done && !tx_busy && (rx_bytes[0] == PT_CMD) &&
                  (rx_len_q >= LEN_W'(2));
    end

    // reply build and state update
    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.pwr = 1'b0;
        ctl_d.rst = 1'b0;
        resp      = '0;
        resp_len  = '0;
        time_load = 1'b0;
        time_val  = {rx_bytes[2], rx_bytes[3], rx_bytes[4], rx_bytes[5]};
        if (op == OP_NONE) begin
            resp[0]  = PT_ERR;
            resp[1]  = ERR_UNKNOWN;
            resp[2]  = PT_CMD;
            resp[3]  = cmd;
            resp_len = TX_LEN_W'(ERR_BYTES);
        end else if (!args_ok || !rate_ok) begin
            resp[0]  = PT_ERR;
            resp[1]  = ERR_BADARG;
            resp[2]  = PT_CMD;
            resp[3]  = cmd;
            resp_len = TX_LEN_W'(ERR_BYTES);
        end else begin
            resp[0]  = PT_CMD;
            resp[1]  = 8'd0;
            resp[2]  = cmd;
            resp_len = TX_LEN_W'(HDR_BYTES);
            case (op)
                OP_AUTOPOLL: begin
                    if (take) ctl_d.autopoll = (rx_bytes[2] != 8'd0);
                end
                OP_SET_RATE: begin
                    if (take) ctl_d.rate = rx_bytes[2];
                end
                OP_SET_DEVLIST: begin
                    if (take) ctl_d.mask = {rx_bytes[2], rx_bytes[3]};
                end
                OP_POWERDOWN: begin
                    ctl_d.pwr = take;
                end
                OP_RESET: begin
                    ctl_d.rst = take;
                end
                OP_GET_TIME: begin
                    resp[3]  = secs[31:24];
                    resp[4]  = secs[23:16];
                    resp[5]  = secs[15:8];
                    resp[6]  = secs[7:0];
                    resp_len = TX_LEN_W'(TX_MAX);
                end
                OP_SET_TIME: begin
                    time_load = take;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.autopoll <= 1'b0;
            ctl_q.rate     <= RATE_RST;
            ctl_q.mask     <= MASK_RST;
            ctl_q.pwr      <= 1'b0;
            ctl_q.rst      <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign autopoll_en   = ctl_q.autopoll;
    assign poll_rate     = ctl_q.rate;
    assign poll_mask     = ctl_q.mask;
    assign powerdown_req = ctl_q.pwr;
    assign sysreset_req  = ctl_q.rst;

    AST_RATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        poll_rate != 8'd0); // R6

    AST_PWR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        powerdown_req |=> !powerdown_req); // R11

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sysreset_req |=> !sysreset_req); // R11

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(powerdown_req && sysreset_req)); // R11

    AST_REQ_WITH_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (powerdown_req || sysreset_req) |-> (tx_valid && tx_first)); // R11

endmodule

// File: tb/host_cmd_dispatch_bench.sv
module host_cmd_dispatch_bench;

    localparam int unsigned DIV   = 7;
    localparam int unsigned LEN_W = 8;
    localparam logic [31:0] SECS0 = 32'h8000_0000;
    localparam logic [7:0] C_AP   = 8'h01;
    localparam logic [7:0] C_GT   = 8'h03;
    localparam logic [7:0] C_ST   = 8'h09;
    localparam logic [7:0] C_PD   = 8'h0A;
    localparam logic [7:0] C_RS   = 8'h11;
    localparam logic [7:0] C_RATE = 8'h14;
    localparam logic [7:0] C_DL   = 8'h19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic             rx_valid = 1'b0;
    logic             rx_first = 1'b0;
    logic [7:0]       rx_data = '0;
    logic [LEN_W-1:0] rx_len = '0;
    logic             tx_valid, tx_first, fwd_valid, fwd_first;
    logic [7:0]       tx_data, fwd_data, poll_rate;
    logic [LEN_W-1:0] tx_len, fwd_len;
    logic             autopoll_en, powerdown_req, sysreset_req;
    logic [15:0]      poll_mask;

    host_cmd_dispatch #(
        .TICK_DIV (DIV), .LEN_W (LEN_W), .RESET_SECS (SECS0),
        .RATE_RST (8'd20), .MASK_RST (16'hFFFF),
        .CMD_AUTOPOLL (C_AP), .CMD_GET_TIME (C_GT), .CMD_SET_TIME (C_ST),
        .CMD_POWERDOWN (C_PD), .CMD_RESET (C_RS), .CMD_SET_RATE (C_RATE),
        .CMD_SET_DEVLIST (C_DL)
    ) u_host_cmd_dispatch (
        .clk (clk), .rst_n (rst_n),
        .rx_valid (rx_valid), .rx_first (rx_first), .rx_data (rx_data), .rx_len (rx_len),
        .tx_valid (tx_valid), .tx_first (tx_first), .tx_data (tx_data), .tx_len (tx_len),
        .fwd_valid (fwd_valid), .fwd_first (fwd_first), .fwd_data (fwd_data), .fwd_len (fwd_len),
        .autopoll_en (autopoll_en), .poll_rate (poll_rate), .poll_mask (poll_mask),
        .powerdown_req (powerdown_req), .sysreset_req (sysreset_req)
    );

    int     checks = 0;
    int     fails = 0;
    bit     finished = 1'b0;
    longint ecnt = 0;
    int     tx_seen = 0;

    always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;
    always @(negedge clk) if (tx_valid) tx_seen <= tx_seen + 1;

    // forwarded-byte capture
    logic [7:0]       fw [0:15];
    bit               fw_f [0:15];
    logic [LEN_W-1:0] fw_len_s;
    int               fw_n = 0;
    always @(negedge clk) begin
        if (fwd_valid && fw_n < 16) begin
            fw[fw_n]   = fwd_data;
            fw_f[fw_n] = fwd_first;
            fw_len_s   = fwd_len;
            fw_n       = fw_n + 1;
        end
    end

    // reference model state
    bit          m_ap = 1'b0;
    logic [7:0]  m_rate = 8'd20;
    logic [15:0] m_mask = 16'hFFFF;
    logic [31:0] m_load_val = SECS0;
    longint      m_load_edge = 0;

    logic [7:0] pk [0:15];
    int         pk_len;
    longint     last_e;
    logic [7:0] ex [0:6];
    int         ex_len;
    bit         ex_pd, ex_rs;
    string      ex_tag;
    string      time_tag = "R9";

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] secs_at(input longint e);
        longint v;
        v = longint'(m_load_val) + (e - 1) / DIV - m_load_edge / DIV;
        return v[31:0];
    endfunction

    // drives pk[], ends at the negedge after the last byte
    task automatic send_pkt();
        for (int i = 0; i < pk_len; i++) begin
            rx_valid = 1'b1;
            rx_first = (i == 0);
            rx_data  = pk[i];
            rx_len   = LEN_W'(pk_len);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_first = 1'b0;
        last_e   = ecnt + 1;
    endtask

    task automatic model_pkt(input longint e);
        logic [7:0]  cmd;
        logic [31:0] t;
        int          need;
        bit          known;
        ex_len = 0; ex_pd = 0; ex_rs = 0; ex_tag = "R13";
        if (pk[0] != 8'd1 || pk_len < 2) return;
        cmd = pk[1];
        known = 1'b1;
        need = 0;
        case (cmd)
            C_AP, C_RATE: need = 1;
            C_DL:         need = 2;
            C_ST:         need = 4;
            C_PD, C_RS, C_GT: need = 0;
            default:      known = 1'b0;
        endcase
        if (!known) begin
            ex[0] = 8'd2; ex[1] = 8'd2; ex[2] = 8'd1; ex[3] = cmd; ex_len = 4; ex_tag = "R4";
        end else if ((pk_len - 2) != need || (cmd == C_RATE && pk[2] == 8'd0)) begin
            ex[0] = 8'd2; ex[1] = 8'd5; ex[2] = 8'd1; ex[3] = cmd; ex_len = 4;
            ex_tag = (cmd == C_RATE && need == pk_len - 2) ? "R6" : "R3";
        end else begin
            ex[0] = 8'd1; ex[1] = 8'd0; ex[2] = cmd; ex_len = 3; ex_tag = "R5";
            case (cmd)
                C_AP:   begin m_ap = (pk[2] != 8'd0); ex_tag = "R8"; end
                C_RATE: begin m_rate = pk[2]; ex_tag = "R6"; end
                C_DL:   begin m_mask = {pk[2], pk[3]}; ex_tag = "R7"; end
                C_PD:   begin ex_pd = 1'b1; ex_tag = "R11"; end
                C_RS:   begin ex_rs = 1'b1; ex_tag = "R11"; end
                C_GT: begin
                    t = secs_at(e);
                    ex[3] = t[31:24]; ex[4] = t[23:16]; ex[5] = t[15:8]; ex[6] = t[7:0];
                    ex_len = 7; ex_tag = time_tag;
                end
                C_ST: begin
                    m_load_val  = {pk[2], pk[3], pk[4], pk[5]};
                    m_load_edge = e;
                    ex_tag = "R9";
                end
                default: ;
            endcase
        end
    endtask

    task automatic check_state(input string tag);
        chk(autopoll_en == m_ap, "R8", {tag, " autopoll"}, autopoll_en, m_ap);
        chk(poll_rate == m_rate, "R6", {tag, " rate"}, poll_rate, m_rate);
        chk(poll_mask == m_mask, "R7", {tag, " mask"}, poll_mask, m_mask);
    endtask

    task automatic run_pkt();
        int seen0;
        seen0 = tx_seen;
        send_pkt();
        model_pkt(last_e);
        if (ex_len == 0) begin
            repeat (10) @(negedge clk);
            chk(tx_seen == seen0, ex_tag, "no reply", tx_seen - seen0, 0);
            chk(!powerdown_req && !sysreset_req, ex_tag, "no request",
                {powerdown_req, sysreset_req}, 0);
            check_state(ex_tag);
        end else begin
            @(negedge clk);
            check_state(ex_tag);
            for (int i = 0; i < ex_len; i++) begin
                chk(tx_valid && (tx_first == (i == 0)) && tx_len == LEN_W'(ex_len), "R2",
                    {ex_tag, " framing"}, {tx_valid, tx_first, tx_len},
                    {1'b1, (i == 0), LEN_W'(ex_len)});
                chk(tx_data == ex[i], ex_tag, $sformatf("byte %0d", i), tx_data, ex[i]);
                chk(powerdown_req == (i == 0 && ex_pd) && sysreset_req == (i == 0 && ex_rs),
                    "R11", "request pulse", {powerdown_req, sysreset_req},
                    {(i == 0 && ex_pd), (i == 0 && ex_rs)});
                @(negedge clk);
            end
            chk(!tx_valid, "R2", "reply end", tx_valid, 0);
        end
    endtask

    task automatic pkt2(input logic [7:0] a, input logic [7:0] b);
        pk[0] = a; pk[1] = b; pk_len = 2;
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(!tx_valid && !fwd_valid, "R1", "streams idle", {tx_valid, fwd_valid}, 0);
        chk(!powerdown_req && !sysreset_req, "R1", "requests", {powerdown_req, sysreset_req}, 0);
        chk(autopoll_en == 1'b0, "R1", "autopoll", autopoll_en, 0);
        chk(poll_rate == 8'd20, "R1", "rate", poll_rate, 20);
        chk(poll_mask == 16'hFFFF, "R1", "mask", poll_mask, 16'hFFFF);
        @(negedge clk);
        // R1 / R9: time from reset value
        pkt2(8'd1, C_GT); run_pkt();

        // R7 device mask byte order
        pk[0] = 1; pk[1] = C_DL; pk[2] = 8'h12; pk[3] = 8'h34; pk_len = 4; run_pkt();
        // R8 autopoll on/off
        pk[0] = 1; pk[1] = C_AP; pk[2] = 8'h80; pk_len = 3; run_pkt();
        pk[2] = 8'h00; run_pkt();
        pk[2] = 8'h01; run_pkt();
        // R6 rate zero rejected, then accepted
        pk[0] = 1; pk[1] = C_RATE; pk[2] = 8'h00; pk_len = 3; run_pkt();
        pk[2] = 8'd50; run_pkt();
        // R11 requests
        pkt2(8'd1, C_PD); run_pkt();
        pkt2(8'd1, C_RS); run_pkt();
        // R9 set then get
        pk[0] = 1; pk[1] = C_ST; pk[2] = 8'hDE; pk[3] = 8'hAD; pk[4] = 8'hBE; pk[5] = 8'hEF;
        pk_len = 6; run_pkt();
        pkt2(8'd1, C_GT); run_pkt();

        // R12 forwarding
        fw_n = 0;
        pk[0] = 0; pk[1] = 8'hA1; pk[2] = 8'hB2; pk[3] = 8'hC3; pk[4] = 8'hD4; pk_len = 5;
        run_pkt();
        chk(fw_n == 4, "R12", "fwd count", fw_n, 4);
        chk(fw_len_s == LEN_W'(4), "R12", "fwd len", fw_len_s, 4);
        for (int i = 0; i < 4; i++) begin
            chk(fw[i] == pk[i + 1] && fw_f[i] == (i == 0), "R12", $sformatf("fwd byte %0d", i),
                {fw_f[i], fw[i]}, {(i == 0), pk[i + 1]});
        end

        // R13 ignored packets
        fw_n = 0;
        pk[0] = 2; pk[1] = C_PD; pk_len = 2; run_pkt();
        pk[0] = 7; pk[1] = C_AP; pk[2] = 8'h01; pk_len = 3; run_pkt();
        pk[0] = 1; pk_len = 1; run_pkt();
        chk(fw_n == 0, "R13", "no forwarding", fw_n, 0);

        // R10 load against tick, every divider phase
        time_tag = "R10";
        for (int ph = 0; ph < 2 * DIV + 1; ph++) begin
            repeat (ph) @(negedge clk);
            pk[0] = 1; pk[1] = C_ST; pk[2] = 8'h01; pk[3] = 8'h23;
            pk[4] = 8'h45; pk[5] = 8'(ph); pk_len = 6; run_pkt();
            repeat (DIV + 2) @(negedge clk);
            pkt2(8'd1, C_GT); run_pkt();
        end
        repeat (3 * DIV) @(negedge clk);
        pkt2(8'd1, C_GT); run_pkt();
        time_tag = "R9";

        // R3 R4 R5 sweep of every command byte and argument count
        for (int c = 0; c < 256; c++) begin
            for (int n = 0; n < 6; n++) begin
                pk[0] = 8'd1;
                pk[1] = 8'(c);
                for (int k = 0; k < n; k++) pk[2 + k] = 8'(c * 3 + k * 29 + n * 7 + 1);
                pk_len = n + 2;
                run_pkt();
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule